// File: doc/BRIEF.md
# Dual-Link Frame Checker and Selector

This block takes the same 256-bit frame from two redundant serial links, A and B. Each frame arrives as eight 32-bit words. The block checks each copy against its own CRC-32 and compares the two transmitted checksum words. From those results it either forwards one copy or raises a dump request.

A forwarded frame appears on the output as its 160-bit channel payload and its 32-bit status word. The block then checks the forwarded frame in two ways. The card identifier must equal an expected value supplied at an input. The frame number must be one more than the frame number of the previous forwarded frame. A single-cycle fault trigger goes high for every anomaly the block finds. The dump, identifier and sequence flags stay set until they are cleared.

A frame counts as received when its last word arrives. The block decides once both copies are in. If only one copy is in, it decides after a fixed number of cycles and treats the absent link as a failed checksum.

Top module: `dual_link_frame_checker`

## Requirements
- R1: Each link is checked on its own. The checksum runs over the first seven words, most significant bit first, with polynomial 0x04C11DB7, initial value all ones, no bit reflection and no final inversion. It is compared with the eighth word.
- R2: If both copies pass but their checksum words differ, there is no forward, `dump_req` sets and `fault_trig` pulses.
- R3: If both copies fail, there is no forward, `dump_req` sets and `fault_trig` pulses.
- R4: If exactly one copy fails, the other copy is forwarded (`fwd_sel_b` = 1 means B) and `fault_trig` pulses.
- R5: If both copies pass and their checksum words agree, copy A is forwarded. `fault_trig` stays low unless R7 or R8 applies.
- R6: Frame layout, from the most significant bit: card identifier [255:240], frame number [239:224], status [223:192], payload [191:32], checksum [31:0]. Words are sent from the most significant word first.
- R7: If a forwarded frame's card identifier differs from `exp_card_id`, `fault_trig` pulses in the decision cycle and `id_mismatch` sets one cycle later.
- R8: If a forwarded frame's number is not the previous forwarded number plus one (modulo 2^16), `fault_trig` pulses and `seq_gap` sets one cycle later. The first forwarded frame after reset is never a gap.
- R9: The decision comes one cycle after the second copy completes. If only one copy has completed, the decision comes TMO_CYC cycles after that copy completes, and the absent copy counts as failed.
- R10: `dump_req`, `id_mismatch` and `seq_gap` are zero after reset. Each holds until a `clr_flags` cycle. A new event in the same cycle as the clear wins over the clear.
- R11: `*_sof` restarts a link's word count, so words received before it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_vld | input | 1 | Link A word valid |
| a_sof | input | 1 | Link A first word of frame |
| a_word | input | 32 | Link A data word |
| b_vld | input | 1 | Link B word valid |
| b_sof | input | 1 | Link B first word of frame |
| b_word | input | 32 | Link B data word |
| exp_card_id | input | 16 | Expected card identifier |
| clr_flags | input | 1 | Clears the sticky flags |
| dec_pulse | output | 1 | A decision was taken this cycle |
| fwd_valid | output | 1 | Payload and status forwarded this cycle |
| fwd_sel_b | output | 1 | Forwarded copy came from link B |
| fwd_payload | output | 160 | Forwarded channel payload |
| fwd_status | output | 32 | Forwarded status word |
| fault_trig | output | 1 | Anomaly seen this cycle |
| dump_req | output | 1 | Sticky dump request |
| id_mismatch | output | 1 | Sticky card identifier mismatch |
| seq_gap | output | 1 | Sticky missing-frame flag |

## Verification
The bench builds the block with its default values: 32-bit words, eight words per frame and TMO_CYC of 16. With a timeout that short, the bench can run single-link arrivals in both directions and check the exact decision cycle. The bench also runs random frames in five modes: clean, copy A corrupted, copy B corrupted, both copies corrupted, and copy B different but with a valid checksum. These modes reach every row of the selection table. Directed cases cover identifier mismatch, a skipped frame number, flag persistence and clearing, and resynchronisation on the start-of-frame input.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int WORD_W  = 32;
  localparam int FRAME_W = 256;
  localparam int NWORDS  = FRAME_W / WORD_W;
  localparam int DATA_W  = FRAME_W - WORD_W;
  localparam int ID_W    = 16;
  localparam int STAT_W  = 32;
  localparam int PAY_W   = 160;
  localparam int CARD_LO = DATA_W - ID_W;
  localparam int FNUM_LO = CARD_LO - ID_W;
  localparam int STAT_LO = FNUM_LO - STAT_W;
  localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [WORD_W-1:0] CRC_INIT = '1;

  typedef struct packed {
    logic dump;
    logic use_b;
    logic fault;
  } verdict_t;

  // One data word folded into the running checksum, MSB first.
  function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] crc,
                                                 input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] c;
    logic fb;
    c = crc;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[WORD_W-1] ^ w[i];
      c  = {c[WORD_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  // Selection table between the two copies.
  function automatic verdict_t judge(input logic ok_a, input logic ok_b,
                                     input logic crc_eq);
    verdict_t v;
    v = '0;
    if (!ok_a && !ok_b) begin
      v.dump = 1'b1; v.fault = 1'b1;
    end else if (ok_a && ok_b) begin
      if (!crc_eq) begin
        v.dump = 1'b1; v.fault = 1'b1;
      end
    end else begin
      v.use_b = ok_b;
      v.fault = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/fc_link_rx.sv
module fc_link_rx
  import fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic              sof,
  input  logic [WORD_W-1:0] word,
  input  logic              consume,
  output logic              have,
  output logic              crc_ok,
  output logic [WORD_W-1:0] crc_rx,
  output logic [DATA_W-1:0] data
);
  localparam int IDX_W = $clog2(NWORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  logic [IDX_W-1:0]  idx_q, idx_e;
  logic [DATA_W-1:0] sr_q;
  logic [WORD_W-1:0] run_q, run_next;
  logic              is_last;
  logic              have_q, ok_q;
  logic [WORD_W-1:0] crc_q;
  logic [DATA_W-1:0] data_q;

  assign idx_e    = sof ? '0 : idx_q;
  assign is_last  = vld && (idx_e == LAST_IDX);
  assign run_next = crc_step((idx_e == '0) ? CRC_INIT : run_q, word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      sr_q   <= '0;
      run_q  <= CRC_INIT;
      have_q <= 1'b0;
      ok_q   <= 1'b0;
      crc_q  <= '0;
      data_q <= '0;
    end else begin
      if (vld) begin
        sr_q  <= {sr_q[DATA_W-WORD_W-1:0], word};
        idx_q <= is_last ? '0 : idx_e + IDX_W'(1);
        if (!is_last) run_q <= run_next;
      end
      if (consume) have_q <= 1'b0;
      if (is_last) begin
        have_q <= 1'b1;
        ok_q   <= (run_q == word);
        crc_q  <= word;
        data_q <= sr_q;
      end
    end
  end

  assign have   = have_q;
  assign crc_ok = ok_q;
  assign crc_rx = crc_q;
  assign data   = data_q;

  // R9: a completed copy waits until the selector takes it
  assert_have_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    have_q && !consume && !is_last |=> have_q);
  // R1: a completed frame always latches the word that closed it
  assert_crc_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_last |=> have_q && crc_q == $past(word));
endmodule

// File: rtl/fc_select.sv
module fc_select
  import fc_pkg::*;
#(
  parameter int TMO_CYC = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  have,
  input  logic [1:0]                  ok,
  input  logic [1:0][WORD_W-1:0]      crc_rx,
  input  logic [1:0][DATA_W-1:0]      data,
  input  logic                        clr,
  output logic                        consume,
  output logic                        dec_pulse,
  output logic                        fwd_valid,
  output logic                        sel_b,
  output logic [PAY_W-1:0]            payload,
  output logic [STAT_W-1:0]           status,
  output logic [ID_W-1:0]             card,
  output logic [ID_W-1:0]             fnum,
  output logic                        link_fault,
  output logic                        dump_req
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(TMO_CYC - 1);

  logic [CNT_W-1:0] wait_q;
  logic one_in, both_in, tmo_hit, decide;
  logic ok_a, ok_b, crc_eq;
  verdict_t verdict;
  logic [DATA_W-1:0] pick;

  assign one_in  = have[0] ^ have[1];
  assign both_in = have[0] & have[1];
  assign tmo_hit = one_in && (wait_q == CNT_END);
  assign decide  = both_in | tmo_hit;
  assign ok_a    = have[0] & ok[0];
  assign ok_b    = have[1] & ok[1];
  assign crc_eq  = (crc_rx[0] == crc_rx[1]);
  assign verdict = judge(ok_a, ok_b, crc_eq);
  assign pick    = verdict.use_b ? data[1] : data[0];
  assign consume = decide;

  logic dec_q, fwd_q, selb_q, fault_q, dump_q;
  logic [PAY_W-1:0] pay_q;
  logic [STAT_W-1:0] stat_q;
  logic [ID_W-1:0] card_q, fnum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= '0;
      dec_q   <= 1'b0;
      fwd_q   <= 1'b0;
      selb_q  <= 1'b0;
      fault_q <= 1'b0;
      dump_q  <= 1'b0;
      pay_q   <= '0;
      stat_q  <= '0;
      card_q  <= '0;
      fnum_q  <= '0;
    end else begin
      wait_q  <= (decide || !one_in) ? '0 : wait_q + CNT_W'(1);
      dec_q   <= decide;
      fwd_q   <= decide && !verdict.dump;
      fault_q <= decide && verdict.fault;
      if (decide && !verdict.dump) begin
        selb_q <= verdict.use_b;
        pay_q  <= pick[PAY_W-1:0];
        stat_q <= pick[STAT_LO +: STAT_W];
        card_q <= pick[CARD_LO +: ID_W];
        fnum_q <= pick[FNUM_LO +: ID_W];
      end
      if (clr) dump_q <= 1'b0;
      if (decide && verdict.dump) dump_q <= 1'b1;
    end
  end

  assign dec_pulse  = dec_q;
  assign fwd_valid  = fwd_q;
  assign sel_b      = selb_q;
  assign payload    = pay_q;
  assign status     = stat_q;
  assign card       = card_q;
  assign fnum       = fnum_q;
  assign link_fault = fault_q;
  assign dump_req   = dump_q;

  assert_both_bad_dump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    decide && !ok_a && !ok_b |=> dump_req && !fwd_valid && link_fault);
  assert_crc_disagree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    decide && ok_a && ok_b && !crc_eq |=> dump_req && !fwd_valid);
  assert_single_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    decide && (ok_a ^ ok_b) |=> fwd_valid && link_fault && (sel_b == $past(ok_b)));
  assert_default_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    decide && ok_a && ok_b && crc_eq |=> fwd_valid && !sel_b && !link_fault);
  assert_dump_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dump_req && !clr |=> dump_req);
  assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    one_in && !decide |=> wait_q <= CNT_END);
endmodule

// File: rtl/fc_seq_check.sv
module fc_seq_check
  import fc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fwd_valid,
  input  logic [ID_W-1:0] card,
  input  logic [ID_W-1:0] fnum,
  input  logic [ID_W-1:0] exp_id,
  input  logic            clr,
  output logic            id_evt,
  output logic            gap_evt,
  output logic            id_flag,
  output logic            gap_flag
);
  logic [ID_W-1:0] prev_q;
  logic            prev_vld_q;
  logic            id_q, gap_q;

  function automatic logic [ID_W-1:0] next_num(input logic [ID_W-1:0] n);
    return n + ID_W'(1);
  endfunction

  assign id_evt  = fwd_valid && (card != exp_id);
  assign gap_evt = fwd_valid && prev_vld_q && (fnum != next_num(prev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      id_q       <= 1'b0;
      gap_q      <= 1'b0;
    end else begin
      if (fwd_valid) begin
        prev_q     <= fnum;
        prev_vld_q <= 1'b1;
      end
      if (clr) begin
        id_q  <= 1'b0;
        gap_q <= 1'b0;
      end
      if (id_evt)  id_q  <= 1'b1;
      if (gap_evt) gap_q <= 1'b1;
    end
  end

  assign id_flag  = id_q;
  assign gap_flag = gap_q;

  assert_id_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_evt |=> id_flag);
  assert_gap_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_evt |=> gap_flag);
  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_flag || gap_flag) && !clr |=> $stable(id_flag) || id_flag);
  assert_gap_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gap_flag && !clr |=> gap_flag);
endmodule

// File: rtl/dual_link_frame_checker.sv
module dual_link_frame_checker
  import fc_pkg::*;
#(
  parameter int TMO_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a_vld,
  input  logic        a_sof,
  input  logic [31:0] a_word,
  input  logic        b_vld,
  input  logic        b_sof,
  input  logic [31:0] b_word,
  input  logic [15:0] exp_card_id,
  input  logic        clr_flags,
  output logic        dec_pulse,
  output logic        fwd_valid,
  output logic        fwd_sel_b,
  output logic [159:0] fwd_payload,
  output logic [31:0] fwd_status,
  output logic        fault_trig,
  output logic        dump_req,
  output logic        id_mismatch,
  output logic        seq_gap
);
  logic [1:0]              vld_v, sof_v, have_v, ok_v;
  logic [1:0][WORD_W-1:0]  word_v, crc_v;
  logic [1:0][DATA_W-1:0]  data_v;
  logic                    consume;
  logic [ID_W-1:0]         card_w, fnum_w;
  logic                    link_fault, id_evt, gap_evt;

  assign vld_v  = {b_vld, a_vld};
  assign sof_v  = {b_sof, a_sof};
  assign word_v = {b_word, a_word};

  for (genvar g = 0; g < 2; g++) begin : g_link
    fc_link_rx u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (vld_v[g]),
      .sof     (sof_v[g]),
      .word    (word_v[g]),
      .consume (consume),
      .have    (have_v[g]),
      .crc_ok  (ok_v[g]),
      .crc_rx  (crc_v[g]),
      .data    (data_v[g])
    );
  end

  fc_select #(.TMO_CYC(TMO_CYC)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .have       (have_v),
    .ok         (ok_v),
    .crc_rx     (crc_v),
    .data       (data_v),
    .clr        (clr_flags),
    .consume    (consume),
    .dec_pulse  (dec_pulse),
    .fwd_valid  (fwd_valid),
    .sel_b      (fwd_sel_b),
    .payload    (fwd_payload),
    .status     (fwd_status),
    .card       (card_w),
    .fnum       (fnum_w),
    .link_fault (link_fault),
    .dump_req   (dump_req)
  );

  fc_seq_check u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd_valid (fwd_valid),
    .card      (card_w),
    .fnum      (fnum_w),
    .exp_id    (exp_card_id),
    .clr       (clr_flags),
    .id_evt    (id_evt),
    .gap_evt   (gap_evt),
    .id_flag   (id_mismatch),
    .gap_flag  (seq_gap)
  );

  assign fault_trig = link_fault | id_evt | gap_evt;

  assert_trig_on_decision_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_trig |-> dec_pulse);
  assert_fwd_excl_dump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> dec_pulse);
endmodule

// File: tb/dual_link_frame_checker_tb.sv
module dual_link_frame_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam logic [15:0] CARD = 16'hC3A5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_vld = 0, a_sof = 0, b_vld = 0, b_sof = 0, clr_flags = 0;
  logic [31:0] a_word = '0, b_word = '0;
  logic [15:0] exp_card_id = CARD;
  logic dec_pulse, fwd_valid, fwd_sel_b, fault_trig, dump_req, id_mismatch, seq_gap;
  logic [159:0] fwd_payload;
  logic [31:0] fwd_status;

  int checks = 0, errors = 0;
  int wait_idx;
  bit got;
  logic [15:0] next_fn = 16'd100;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_link_frame_checker #(.TMO_CYC(TMO)) u_dut (.*);

  function automatic logic [31:0] ref_crc(input logic [223:0] d);
    logic [31:0] c = '1;
    for (int i = 223; i >= 0; i--) begin
      logic fb = c[31] ^ d[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic logic [255:0] mk(input logic [15:0] card, input logic [15:0] fn,
                                      input logic [31:0] st, input logic [159:0] pay);
    logic [223:0] d = {card, fn, st, pay};
    return {d, ref_crc(d)};
  endfunction

  function automatic logic [159:0] rnd_pay();
    return {$urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [159:0] act,
                     input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic send(input logic [255:0] fa, input logic [255:0] fb,
                      input bit en_a, input bit en_b);
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      a_vld = en_a; a_sof = (w == 0); a_word = fa[255 - 32*w -: 32];
      b_vld = en_b; b_sof = (w == 0); b_word = fb[255 - 32*w -: 32];
    end
    @(negedge clk);
    a_vld = 0; a_sof = 0; b_vld = 0; b_sof = 0;
  endtask

  task automatic wait_dec();
    got = 0; wait_idx = -1;
    for (int i = 0; i < TMO + 20; i++) begin
      if (i > 0) @(negedge clk);
      if (dec_pulse) begin got = 1; wait_idx = i; break; end
    end
  endtask

  task automatic clear();
    @(negedge clk); clr_flags = 1;
    @(negedge clk); clr_flags = 0;
  endtask

  // mode: 0 clean, 1 A corrupt, 2 B corrupt, 3 both corrupt, 4 B differs with valid CRC
  task automatic run_mode(input int mode);
    logic [159:0] pa = rnd_pay();
    logic [31:0]  st = $urandom;
    logic [255:0] fa = mk(CARD, next_fn, st, pa);
    logic [255:0] fb = fa;
    logic [255:0] flip = 256'b1 << (32 + ($urandom % 224));
    bit e_dump, e_selb, e_trig;
    if (mode == 1 || mode == 3) fa = fa ^ flip;
    if (mode == 2 || mode == 3) fb = fb ^ (256'b1 << (32 + ($urandom % 224)));
    if (mode == 4) fb = mk(CARD, next_fn, st, pa ^ 160'h1);
    e_dump = (mode == 3 || mode == 4);
    e_selb = (mode == 1);
    e_trig = (mode != 0);
    send(fa, fb, 1, 1);
    @(negedge clk);
    wait_dec();
    chk(got && wait_idx == 0, "R9 decision one cycle after both", wait_idx, 0);
    chk(fwd_valid == !e_dump, e_dump ? "R2/R3 no forward on dump" : "R4/R5 forward", fwd_valid, !e_dump);
    chk(fault_trig == e_trig, "R4 R5 R2 R3 trigger", fault_trig, e_trig);
    chk(dump_req == e_dump, "R2 R3 dump", dump_req, e_dump);
    if (!e_dump) begin
      chk(fwd_sel_b == e_selb, "R4 R5 selected link", fwd_sel_b, e_selb);
      chk(fwd_payload == pa, "R6 payload", fwd_payload, pa);
      chk(fwd_status == st, "R6 status", fwd_status, st);
      next_fn++;
    end
    @(negedge clk);
    chk(!seq_gap && !id_mismatch, "R7 R8 no flag on good sequence", {seq_gap, id_mismatch}, 0);
    if (e_dump) clear();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [159:0] p;
    logic [255:0] f;
    process_seed: begin
      void'($urandom(32'd1234));
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!dec_pulse && !fwd_valid && !fault_trig, "R10 reset outputs", {dec_pulse, fwd_valid, fault_trig}, 0);
    chk(!dump_req && !id_mismatch && !seq_gap, "R10 reset flags", {dump_req, id_mismatch, seq_gap}, 0);

    // Directed table rows
    for (int m = 0; m < 5; m++) run_mode(m);

    // R11: stray words before a start-of-frame are discarded
    p = rnd_pay();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); a_vld = 1; a_sof = 0; a_word = $urandom;
    end
    f = mk(CARD, next_fn, 32'h0, p);
    send(f, f, 1, 1);
    @(negedge clk); wait_dec();
    chk(got && fwd_valid && !fwd_sel_b && !fault_trig, "R11 resync on sof", {fwd_valid, fwd_sel_b, fault_trig}, 3'b100);
    chk(fwd_payload == p, "R11 payload after resync", fwd_payload, p);
    next_fn++;

    // R9: timeout with B absent, then with A absent
    p = rnd_pay();
    f = mk(CARD, next_fn, 32'hA5, p);
    send(f, f, 1, 0);
    @(negedge clk); wait_dec();
    chk(got && wait_idx == TMO - 1, "R9 timeout cycle (B absent)", wait_idx, TMO - 1);
    chk(fwd_valid && !fwd_sel_b && fault_trig, "R9 absent B counts as fail", {fwd_valid, fwd_sel_b, fault_trig}, 3'b101);
    next_fn++;
    p = rnd_pay();
    f = mk(CARD, next_fn, 32'h5A, p);
    send(f, f, 0, 1);
    @(negedge clk); wait_dec();
    chk(got && wait_idx == TMO - 1, "R9 timeout cycle (A absent)", wait_idx, TMO - 1);
    chk(fwd_valid && fwd_sel_b && fwd_payload == p, "R9 absent A selects B", {fwd_valid, fwd_sel_b}, 2'b11);
    next_fn++;

    // R10: dump holds until cleared, even across a clean frame
    f = mk(CARD, next_fn, 0, rnd_pay());
    send(f ^ (256'b1 << 40), f ^ (256'b1 << 41), 1, 1);
    @(negedge clk); wait_dec();
    repeat (5) @(negedge clk);
    chk(dump_req, "R10 dump holds", dump_req, 1);
    f = mk(CARD, next_fn, 0, rnd_pay());
    send(f, f, 1, 1);
    @(negedge clk); wait_dec();
    chk(dump_req && fwd_valid, "R10 dump sticky across good frame", {dump_req, fwd_valid}, 2'b11);
    next_fn++;
    clear();
    chk(!dump_req, "R10 dump cleared", dump_req, 0);

    // R7: card identifier mismatch
    f = mk(CARD ^ 16'h0100, next_fn, 0, rnd_pay());
    send(f, f, 1, 1);
    @(negedge clk); wait_dec();
    chk(fault_trig && fwd_valid, "R7 trigger on id mismatch", fault_trig, 1);
    @(negedge clk);
    chk(id_mismatch && !seq_gap, "R7 id flag set", {id_mismatch, seq_gap}, 2'b10);
    next_fn++;
    repeat (4) @(negedge clk);
    chk(id_mismatch, "R10 id flag sticky", id_mismatch, 1);
    clear();
    chk(!id_mismatch, "R10 id flag cleared", id_mismatch, 0);

    // R8: skipped frame number
    f = mk(CARD, next_fn + 16'd1, 0, rnd_pay());
    send(f, f, 1, 1);
    @(negedge clk); wait_dec();
    chk(fault_trig, "R8 trigger on gap", fault_trig, 1);
    @(negedge clk);
    chk(seq_gap && !id_mismatch, "R8 gap flag set", {seq_gap, id_mismatch}, 2'b10);
    next_fn = next_fn + 16'd2;
    f = mk(CARD, next_fn, 0, rnd_pay());
    send(f, f, 1, 1);
    @(negedge clk); wait_dec();
    chk(!fault_trig && seq_gap, "R8 in-order after gap, flag held", {fault_trig, seq_gap}, 2'b01);
    next_fn++;
    clear();
    chk(!seq_gap, "R10 gap flag cleared", seq_gap, 0);

    // Random mix over the table (R1..R6)
    for (int n = 0; n < 60; n++) run_mode($urandom % 5);

    summary();
  end
endmodule